// File: doc/BRIEF.md
# Audio serial frame engine

This block drives the transmit side of a time-division-multiplexed audio serial port. From a master clock it makes a bit clock through an even divider. It produces a frame sync pulse and shifts out one parallel sample per active slot. Four settings cover the common framings: where the sync pulse sits (on the first data bit or one bit earlier), how wide it is (one bit or one whole slot), and the polarity of the sync and of the bit clock. With them one engine gives I2S, left-justified, DSP-A and DSP-B style frames.

Samples enter through a ready/valid handshake. A sample is taken only at the start of a slot that is not masked. Slot count, word length, bit order and the per-slot mask are plain configuration inputs. They are expected to stay steady while the engine is active. Clearing the enable does not cut a frame short: the engine finishes the frame it is in, then goes idle.

Top module: `tdm_frame_tx`

## Requirements
- R1: One bit period lasts 2*(cfg_div_i+1) master clock cycles. The 8-bit divider field therefore gives even ratios from 2 to 512.
- R2: With cfg_bclk_inv_i=0, bclk_o is low in the first half of each bit and high in the second half. dout_o and fs_o change only while bclk_o is low, and are sampled on its rising edge. With cfg_bclk_inv_i=1, bclk_o is inverted.
- R3: With cfg_early_i=0, the sync is active during every bit of slot 0 when cfg_fs_word_i=1, and only during the first bit of slot 0 when cfg_fs_word_i=0.
- R4: With cfg_early_i=1, the whole sync pattern moves one bit earlier, so the sync is active during the last bit of the previous frame. In the first frame after enable, that leading bit is absent.
- R5: With cfg_fs_inv_i=1, fs_o is the inverse of the active-high sync. When idle, fs_o equals cfg_fs_inv_i.
- R6: A frame has cfg_slots_i slots (1 to MAX_SLOTS). Each slot has cfg_wlen_i+1 bits.
- R7: With cfg_msb_first_i=1, the bits of a slot are sent from index cfg_wlen_i down to 0. With cfg_msb_first_i=0, they are sent from index 0 up to cfg_wlen_i. Bits of s_data_i above cfg_wlen_i are never sent.
- R8: When bit s of cfg_mask_i is 1, slot s sends all zeros and takes no sample. s_ready_o is not raised for it, and the pending sample goes to the next unmasked slot.
- R9: At the start of each unmasked slot, s_ready_o is high for exactly one cycle. The sample is taken when s_valid_i is also high.
- R10: If s_valid_i is low at the start of an unmasked slot, that slot sends zeros and underrun_o pulses for one cycle. No sample is taken.
- R11: When en_i is high while the engine is idle, the engine starts at bit 0 of slot 0 with its bit clock phase reset. When en_i is cleared, active_o stays high until the last bit of the current frame has been sent, and then falls.
- R12: After reset, active_o, bclk_o (with cfg_bclk_inv_i=0), fs_o (with cfg_fs_inv_i=0), dout_o and s_ready_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request |
| cfg_div_i | input | DIV_W | Half bit period minus one, in master clock cycles |
| cfg_bclk_inv_i | input | 1 | Invert the bit clock |
| cfg_fs_inv_i | input | 1 | Make the sync active low |
| cfg_early_i | input | 1 | Place the sync one bit before the frame |
| cfg_fs_word_i | input | 1 | Sync width: 1 = one slot, 0 = one bit |
| cfg_slots_i | input | $clog2(MAX_SLOTS+1) | Slots per frame |
| cfg_wlen_i | input | $clog2(MAX_WORD) | Bits per slot minus one |
| cfg_msb_first_i | input | 1 | Bit order: 1 = high index first |
| cfg_mask_i | input | MAX_SLOTS | Per-slot mute, 1 = slot masked |
| s_valid_i | input | 1 | Sample valid |
| s_data_i | input | MAX_WORD | Sample word |
| s_ready_o | output | 1 | Sample taken this cycle if valid |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| dout_o | output | 1 | Serial data |
| active_o | output | 1 | Engine running |
| underrun_o | output | 1 | No sample at the start of an unmasked slot |

## Verification
The bench builds the block with its defaults: 8 slots, 32-bit words and an 8-bit divider. This covers a full 8-slot frame, a word whose first bit is index 31, and both ends of the divider range (ratio 2 and ratio 512). A monitor rebuilds the frame from bclk_o and compares every sync and data bit with a model written from the requirements. Each run stops in the middle of its last frame, so the frame-completion rule is exercised every time.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef enum logic {FS_ONE_BIT = 1'b0, FS_ONE_WORD = 1'b1} fs_width_e;

  // active-high sync level for the bit at a given frame position
  function automatic logic fs_level(logic early, fs_width_e width, logic slot_zero,
                                    logic bit_zero, logic bit_last, logic frame_last);
    if (early)
      return (width == FS_ONE_WORD) ? ((slot_zero && !bit_last) || frame_last) : frame_last;
    else
      return (width == FS_ONE_WORD) ? slot_zero : (slot_zero && bit_zero);
  endfunction
endpackage

// File: rtl/tdm_bclk_div.sv
module tdm_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ph_o,
  output logic             adv_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             ph_q;
  logic             hit;

  assign hit   = (cnt_q == div_i);
  assign ph_o  = ph_q;
  assign adv_o = run_i && hit && ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (start_i || !run_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |-> (cnt_q <= div_i)); // R1

  AST_PH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && !hit) |=> $stable(ph_q)); // R1
endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WORD  = 32,
  localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int SLOT_CW  = $clog2(MAX_SLOTS + 1),
  localparam int BIT_W    = $clog2(MAX_WORD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               adv_i,
  input  logic [SLOT_CW-1:0] cfg_slots_i,
  input  logic [BIT_W-1:0]   cfg_wlen_i,
  output logic               active_o,
  output logic               start_o,
  output logic               load_o,
  output logic               stop_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [SLOT_W-1:0]  nslot_o,
  output logic [BIT_W-1:0]   nbit_o
);
  logic              active_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic              bit_last, frame_last;

  assign bit_last   = (bit_q == cfg_wlen_i);
  assign frame_last = bit_last && (SLOT_CW'(slot_q) == SLOT_CW'(cfg_slots_i - 1'b1));
  assign start_o    = !active_q && en_i;
  assign stop_o     = adv_i && frame_last && !en_i;
  assign load_o     = start_o || (adv_i && !stop_o);
  assign active_o   = active_q;
  assign slot_o     = slot_q;

  always_comb begin
    if (start_o || frame_last) begin
      nslot_o = '0;
      nbit_o  = '0;
    end else if (bit_last) begin
      nslot_o = slot_q + 1'b1;
      nbit_o  = '0;
    end else begin
      nslot_o = slot_q;
      nbit_o  = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else if (stop_o) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      slot_q   <= nslot_o;
      bit_q    <= nbit_o;
    end
  end

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !(adv_i && frame_last)) |=> active_q); // R11

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (SLOT_CW'(slot_q) < cfg_slots_i)); // R6

  AST_START_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (slot_q == '0 && bit_q == '0)); // R11
endmodule

// File: rtl/tdm_slot_shift.sv
module tdm_slot_shift
  import tdm_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WORD  = 32,
  localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int SLOT_CW  = $clog2(MAX_SLOTS + 1),
  localparam int BIT_W    = $clog2(MAX_WORD)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 stop_i,
  input  logic [SLOT_W-1:0]    nslot_i,
  input  logic [BIT_W-1:0]     nbit_i,
  input  logic [SLOT_CW-1:0]   cfg_slots_i,
  input  logic [BIT_W-1:0]     cfg_wlen_i,
  input  logic [MAX_SLOTS-1:0] cfg_mask_i,
  input  logic                 cfg_msb_first_i,
  input  logic                 cfg_early_i,
  input  logic                 cfg_fs_word_i,
  input  logic                 s_valid_i,
  input  logic [MAX_WORD-1:0]  s_data_i,
  output logic                 s_ready_o,
  output logic                 underrun_o,
  output logic                 dout_o,
  output logic                 fs_o
);
  logic [MAX_WORD-1:0] smp_q, cur_word;
  logic [BIT_W-1:0]    idx;
  logic                slot_start, slot_open, take_win, fs_d, nbit_last;

  assign slot_start = (nbit_i == '0);
  assign slot_open  = !cfg_mask_i[nslot_i];
  assign take_win   = load_i && slot_start && slot_open;
  assign s_ready_o  = take_win;
  assign underrun_o = take_win && !s_valid_i;
  assign nbit_last  = (nbit_i == cfg_wlen_i);
  assign idx        = cfg_msb_first_i ? (cfg_wlen_i - nbit_i) : nbit_i;

  always_comb begin
    if (slot_start) cur_word = (slot_open && s_valid_i) ? s_data_i : '0;
    else            cur_word = smp_q;
  end

  assign fs_d = fs_level(cfg_early_i, fs_width_e'(cfg_fs_word_i), nslot_i == '0,
                         slot_start, nbit_last,
                         nbit_last && (SLOT_CW'(nslot_i) == SLOT_CW'(cfg_slots_i - 1'b1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      dout_o <= 1'b0;
      fs_o   <= 1'b0;
    end else if (stop_i) begin
      smp_q  <= '0;
      dout_o <= 1'b0;
      fs_o   <= 1'b0;
    end else if (load_i) begin
      smp_q  <= cur_word;
      dout_o <= cur_word[idx];
      fs_o   <= fs_d;
    end
  end

  AST_UNDERRUN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !dout_o); // R10

  AST_READY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |=> !s_ready_o); // R9
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WORD  = 32,
  parameter int DIV_W     = 8,
  localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int SLOT_CW  = $clog2(MAX_SLOTS + 1),
  localparam int BIT_W    = $clog2(MAX_WORD)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [DIV_W-1:0]     cfg_div_i,
  input  logic                 cfg_bclk_inv_i,
  input  logic                 cfg_fs_inv_i,
  input  logic                 cfg_early_i,
  input  logic                 cfg_fs_word_i,
  input  logic [SLOT_CW-1:0]   cfg_slots_i,
  input  logic [BIT_W-1:0]     cfg_wlen_i,
  input  logic                 cfg_msb_first_i,
  input  logic [MAX_SLOTS-1:0] cfg_mask_i,
  input  logic                 s_valid_i,
  input  logic [MAX_WORD-1:0]  s_data_i,
  output logic                 s_ready_o,
  output logic                 bclk_o,
  output logic                 fs_o,
  output logic                 dout_o,
  output logic                 active_o,
  output logic                 underrun_o
);
  logic              start, load, stop, adv, ph, fs_raw;
  logic [SLOT_W-1:0] slot, nslot;
  logic [BIT_W-1:0]  nbit;

  tdm_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .start_i(start), .run_i(active_o), .div_i(cfg_div_i),
    .ph_o(ph), .adv_o(adv)
  );

  tdm_frame_seq #(.MAX_SLOTS(MAX_SLOTS), .MAX_WORD(MAX_WORD)) u_seq (
    .clk_i, .rst_ni, .en_i, .adv_i(adv), .cfg_slots_i, .cfg_wlen_i,
    .active_o, .start_o(start), .load_o(load), .stop_o(stop),
    .slot_o(slot), .nslot_o(nslot), .nbit_o(nbit)
  );

  tdm_slot_shift #(.MAX_SLOTS(MAX_SLOTS), .MAX_WORD(MAX_WORD)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .stop_i(stop), .nslot_i(nslot), .nbit_i(nbit),
    .cfg_slots_i, .cfg_wlen_i, .cfg_mask_i, .cfg_msb_first_i, .cfg_early_i,
    .cfg_fs_word_i, .s_valid_i, .s_data_i, .s_ready_o, .underrun_o,
    .dout_o, .fs_o(fs_raw)
  );

  assign bclk_o = ph ^ cfg_bclk_inv_i;
  assign fs_o   = fs_raw ^ cfg_fs_inv_i;

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && cfg_mask_i[slot]) |-> !dout_o); // R8

  AST_IDLE_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (fs_o == cfg_fs_inv_i)); // R5

  AST_EDGE_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o) && !$stable(dout_o)) |-> !ph); // R2
endmodule

// File: tb/tb_tdm_frame_tx.sv
`timescale 1ns/1ps
module tb_tdm_frame_tx;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        binv = 1'b0, finv = 1'b0, early = 1'b0, fsw = 1'b0, msb = 1'b1;
  logic [3:0]  slots = 4'd2;
  logic [4:0]  wlen = 5'd15;
  logic [7:0]  mask = '0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, bclk, fs, dout, active, underrun;

  always #4 clk = ~clk;

  tdm_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_div_i(cfg_div),
    .cfg_bclk_inv_i(binv), .cfg_fs_inv_i(finv), .cfg_early_i(early),
    .cfg_fs_word_i(fsw), .cfg_slots_i(slots), .cfg_wlen_i(wlen),
    .cfg_msb_first_i(msb), .cfg_mask_i(mask), .s_valid_i(s_valid),
    .s_data_i(s_data), .s_ready_o(s_ready), .bclk_o(bclk), .fs_o(fs),
    .dout_o(dout), .active_o(active), .underrun_o(underrun)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, cap_n = 0, glitch = 0, ur_n = 0, take_n = 0;
  int src_idx = 0, src_n = 0;
  logic cap_fs [0:1023];
  logic cap_d  [0:1023];
  int   cap_t  [0:1023];
  logic [31:0] smp [0:255];
  logic prev_ph = 1'b0, prev_d = 1'b0, prev_fs = 1'b0, fire_q = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: rebuild bits at the sampling edge of the bit clock
  always @(negedge clk) begin
    logic ph_obs;
    cyc++;
    ph_obs = bclk ^ binv;
    if (ph_obs && !prev_ph && cap_n < 1024) begin
      cap_fs[cap_n] = fs ^ finv;
      cap_d[cap_n]  = dout;
      cap_t[cap_n]  = cyc;
      cap_n++;
    end
    if (ph_obs && (dout !== prev_d || fs !== prev_fs)) glitch++;
    prev_ph = ph_obs;
    prev_d  = dout;
    prev_fs = fs;
    if (underrun) ur_n++;
    fire_q = s_ready && s_valid;
    if (fire_q) take_n++;
  end

  // sample source
  always @(posedge clk) begin
    #2;
    if (fire_q) src_idx++;
    s_valid = (src_idx < src_n);
    s_data  = smp[src_idx & 255];
  end

  task automatic t_reset();
    #1;
    chk("R12 active after reset", int'(active), 0);
    chk("R12 bclk after reset", int'(bclk), 0);
    chk("R12 fs after reset", int'(fs), 0);
    chk("R12 dout after reset", int'(dout), 0);
    chk("R12 ready after reset", int'(s_ready), 0);
  endtask

  task automatic run_case(input string tag, input int n_sl, input int wl, input bit m_first,
                          input logic [7:0] msk, input bit erl, input bit wide,
                          input bit bi, input bit fi, input int dv, input int nfr,
                          input int nsmp);
    int w, f, tot, ptr, fs_bad, d_bad, per_bad, exp_ur, exp_take;
    logic [31:0] cur;
    w = wl + 1;
    f = n_sl * w;
    tot = nfr * f;
    @(posedge clk); #1;
    slots = 4'(n_sl); wlen = 5'(wl); msb = m_first; mask = msk; early = erl;
    fsw = wide; binv = bi; finv = fi; cfg_div = 8'(dv);
    for (int i = 0; i < 256; i++) smp[i] = (32'h9E37_79B9 * (i + 3)) ^ (32'h5A5A_0F0F >> (i % 7));
    src_n = nsmp;
    @(posedge clk); #1;
    prev_ph = 1'b0;
    cap_n = 0; glitch = 0; ur_n = 0; take_n = 0; src_idx = 0;
    @(posedge clk); #3;
    chk({tag, " R5 idle fs level"}, int'(fs), int'(fi));
    en = 1'b1;
    while (cap_n < (nfr - 1) * f + 1) @(negedge clk);
    @(posedge clk); #3;
    en = 1'b0;
    @(negedge clk);
    while (active) @(negedge clk);
    repeat (4) @(negedge clk);
    chk({tag, " R11 bits until idle"}, cap_n, tot);
    // expected stream
    ptr = 0; fs_bad = 0; d_bad = 0; exp_ur = 0; exp_take = 0; cur = '0;
    for (int k = 0; k < tot && k < 1024; k++) begin
      int pos, s, b, g, bi_idx;
      logic efs;
      pos = k % f; s = pos / w; b = pos % w;
      if (erl) begin
        g = (k + 1) % f;
        efs = wide ? (g < w) : (g == 0);
      end else begin
        efs = wide ? (pos < w) : (pos == 0);
      end
      if (b == 0) begin
        if (msk[s]) cur = '0;
        else if (ptr < nsmp) begin cur = smp[ptr]; ptr++; exp_take++; end
        else begin cur = '0; exp_ur++; end
      end
      bi_idx = m_first ? (wl - b) : b;
      if (cap_fs[k] !== efs) begin
        if (fs_bad == 0) $display("FAIL %s R3/R4 fs bit %0d act=%0d exp=%0d", tag, k, cap_fs[k], efs);
        fs_bad++;
      end
      if (cap_d[k] !== cur[bi_idx]) begin
        if (d_bad == 0) $display("FAIL %s R7/R8 data bit %0d act=%0d exp=%0d", tag, k, cap_d[k], cur[bi_idx]);
        d_bad++;
      end
    end
    per_bad = 0;
    for (int k = 1; k < cap_n && k < 1024; k++)
      if (cap_t[k] - cap_t[k-1] != 2 * (dv + 1)) per_bad++;
    chk({tag, " R3 R4 R5 frame sync mismatches"}, fs_bad, 0);
    chk({tag, " R6 R7 R8 data mismatches"}, d_bad, 0);
    chk({tag, " R2 changes in second half"}, glitch, 0);
    chk({tag, " R1 bit period errors"}, per_bad, 0);
    chk({tag, " R9 samples taken"}, take_n, exp_take);
    chk({tag, " R10 underrun pulses"}, ur_n, exp_ur);
  endtask

  task automatic t_i2s();       run_case("i2s",      2, 31, 1, 8'h00, 1, 1, 0, 1, 1, 2, 64); endtask
  task automatic t_leftj();     run_case("leftj",    2, 23, 1, 8'h00, 0, 1, 0, 0, 0, 3, 64); endtask
  task automatic t_dsp_a();     run_case("dspa",     4, 15, 1, 8'h00, 1, 0, 0, 0, 2, 2, 64); endtask
  task automatic t_dsp_b();     run_case("dspb",     8,  7, 0, 8'h00, 0, 0, 1, 0, 0, 2, 64); endtask
  task automatic t_mask();      run_case("mask R8",  4, 11, 1, 8'h0C, 0, 1, 0, 0, 1, 3, 64); endtask
  task automatic t_underrun();  run_case("urun R10", 2,  7, 1, 8'h00, 0, 1, 0, 0, 0, 3, 3);  endtask
  task automatic t_slow_div();  run_case("div R1",   1,  3, 0, 8'h00, 0, 0, 0, 0, 255, 2, 8); endtask
  task automatic t_restart();   run_case("restart R11", 3, 4, 0, 8'h02, 1, 1, 1, 1, 0, 2, 64); endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_i2s();
    t_leftj();
    t_dsp_a();
    t_dsp_b();
    t_mask();
    t_underrun();
    t_slow_div();
    t_restart();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule